// File: doc/BRIEF.md
# SMBus Packet-Check Transfer-End Sequencer

This block sits between a DMA channel and an I2C byte shift engine. It closes a DMA-driven transfer correctly when SMBus packet error checking is in use. It keeps a running CRC-8 over every byte that crosses the shift engine, including address bytes. It also decides what happens when the DMA reports that its count is running out.

In transmit, the DMA end-of-transfer indication arms the block. After the next completed byte, which is the last data byte, the block pulses a select strobe for one cycle. The strobe tells the shift engine to load the CRC value in place of the data register, so the checksum goes out as the final byte.

In receive, the DMA "one transfer left" indication marks the next incoming byte as the final one. That byte is answered with NACK when the block is a master and software has declared the transfer final. If checking is enabled, the byte is compared against the running CRC, and a mismatch sets a sticky error flag. Every received byte, including the checksum byte, produces a DMA request, so the checksum also lands in memory. When software declares the transfer not final, the end indication changes nothing and the transfer stays open for a later segment. An arbitration-loss input marks the running CRC as untrustworthy until it is next cleared.

Top module: `i2c_pec_seq`

## Requirements
- R1: While `pec_en_i` is high, every `byte_done_i` updates `pec_o` in the following cycle. The new value is the CRC-8 of the previous value and `byte_i`, with polynomial x^8+x^2+x+1 (0x07), processed MSB first. With `pec_en_i` low, `pec_o` holds its value.
- R2: `pec_o` is 0x00 after reset and in the cycle after `start_i` or `pec_clr_i`. A clear takes priority over a byte update in the same cycle.
- R3: Transmit (`mode_tx_i`=1) arming happens on `dma_eot_i` when `dma_en_i`, `pec_en_i` and `last_i` are all high. Once armed, the next `byte_done_i` makes `tx_pec_select_o` high for exactly the following cycle. Sending that checksum byte back through `byte_i` returns `pec_o` to 0x00.
- R4: `dma_eot_i` with `last_i` low or `pec_en_i` low produces no `tx_pec_select_o` pulse.
- R5: Receive (`mode_tx_i`=0) arming happens on `dma_eot1_i` when `dma_en_i` and `last_i` are high. While armed, `nack_o` equals `master_i`. The next `byte_done_i` disarms the block, and `nack_o` is low for every other byte.
- R6: If `pec_en_i` was high at arming, the final received byte is compared with the `pec_o` value in place before that byte. On a mismatch, `pec_err_o` rises in the following cycle.
- R7: `pec_err_o` is low after reset and stays high until a `pec_err_clr_i` cycle. When a clear and a new mismatch occur in the same cycle, the flag stays set.
- R8: In receive mode with `dma_en_i` high, every `byte_done_i` makes `rx_dma_req_o` high for exactly the following cycle. This includes the checksum byte.
- R9: `pec_valid_o` is high after reset. It falls in the cycle after `arb_lost_i` and returns high only after `start_i` or `pec_clr_i`.
- R10: `dma_eot1_i` with `last_i` low arms nothing. The next byte is ACKed and no comparison is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | DMA transfers enabled |
| pec_en_i | input | 1 | Packet checksum enabled |
| last_i | input | 1 | Current DMA transfer is the final one |
| master_i | input | 1 | Block acts as bus master |
| mode_tx_i | input | 1 | 1 = transmit, 0 = receive |
| start_i | input | 1 | START condition seen (clears CRC) |
| pec_clr_i | input | 1 | Software checksum reset |
| arb_lost_i | input | 1 | Arbitration lost |
| dma_eot_i | input | 1 | DMA end of transfer |
| dma_eot1_i | input | 1 | DMA one transfer remaining |
| byte_done_i | input | 1 | Shift engine finished a byte |
| byte_i | input | 8 | Byte just shifted |
| pec_err_clr_i | input | 1 | Software clear of the error flag |
| pec_o | output | 8 | Running CRC-8 |
| pec_valid_o | output | 1 | CRC not corrupted by arbitration loss |
| tx_pec_select_o | output | 1 | Load checksum instead of data for the next byte |
| nack_o | output | 1 | Answer the byte in flight with NACK |
| rx_dma_req_o | output | 1 | DMA request for a received byte |
| pec_err_o | output | 1 | Sticky checksum mismatch (error interrupt source) |

## Verification
The bench builds the block with its default polynomial 0x07 and initial value 0x00. These values match a bitwise software CRC-8, so random byte streams and appended checksums can be checked against known residues; a zero residue after the checksum byte shows that the polynomial and bit order are right. The default width of one byte keeps every checksum value, and every mismatch case, within reach of directed and random stimulus in a few hundred cycles.

// File: rtl/pec_seq_pkg.sv
package pec_seq_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // one byte through an MSB-first CRC, whole byte folded in at once
  function automatic byte_t crc_step(byte_t crc, byte_t data, byte_t poly);
    byte_t c;
    c = crc ^ data;
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[BYTE_W-1] ? byte_t'((c << 1) ^ poly) : byte_t'(c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/pec_crc_unit.sv
module pec_crc_unit
  import pec_seq_pkg::*;
#(
  parameter byte_t POLY = 8'h07,
  parameter byte_t INIT = 8'h00
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  upd_i,
  input  byte_t data_i,
  input  logic  arb_lost_i,
  output byte_t crc_o,
  output logic  valid_o
);
  byte_t crc_q;
  logic  valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= INIT;
    else if (clr_i) crc_q <= INIT;
    else if (upd_i) crc_q <= crc_step(crc_q, data_i, POLY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         valid_q <= 1'b1;
    else if (clr_i)      valid_q <= 1'b1;
    else if (arb_lost_i) valid_q <= 1'b0;
  end

  assign crc_o   = crc_q;
  assign valid_o = valid_q;

  a_r2_clear_to_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_q == INIT);
  a_r1_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !upd_i) |=> $stable(crc_q));
  a_r9_arb_invalidates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_i && !clr_i) |=> !valid_q);
endmodule

// File: rtl/pec_tx_seq.sv
module pec_tx_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic arm_i,
  input  logic byte_done_i,
  output logic sel_o
);
  logic pend_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (start_i)     pend_q <= 1'b0;
    else if (arm_i)       pend_q <= 1'b1;
    else if (byte_done_i) pend_q <= 1'b0;
  end

  // pulse after the last data byte completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= byte_done_i & pend_q & ~start_i;
  end

  assign sel_o = sel_q;

  a_r3_sel_follows_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q |-> $past(byte_done_i));
  a_r4_sel_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q |-> $past(pend_q));
endmodule

// File: rtl/pec_rx_seq.sv
module pec_rx_seq
  import pec_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  arm_i,
  input  logic  chk_en_i,
  input  logic  master_i,
  input  logic  rx_mode_i,
  input  logic  dma_en_i,
  input  logic  byte_done_i,
  input  byte_t byte_i,
  input  byte_t crc_i,
  input  logic  err_clr_i,
  output logic  nack_o,
  output logic  req_o,
  output logic  err_o
);
  logic armed_q, chk_q, req_q, err_q;
  logic err_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      chk_q   <= 1'b0;
    end else if (start_i) begin
      armed_q <= 1'b0;
      chk_q   <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      chk_q   <= chk_en_i;
    end else if (byte_done_i) begin
      armed_q <= 1'b0;
    end
  end

  assign err_set = byte_done_i & armed_q & chk_q & (byte_i != crc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      err_q <= err_set | (err_q & ~err_clr_i);
      req_q <= byte_done_i & rx_mode_i & dma_en_i;
    end
  end

  assign nack_o = armed_q & master_i;
  assign req_o  = req_q;
  assign err_o  = err_q;

  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr_i) |=> err_q);
  a_r6_err_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(armed_q && chk_q && byte_done_i));
  a_r8_req_after_rx_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(byte_done_i && rx_mode_i));
  a_r5_nack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && byte_done_i && !arm_i) |=> !nack_o);
endmodule

// File: rtl/i2c_pec_seq.sv
module i2c_pec_seq
  import pec_seq_pkg::*;
#(
  parameter byte_t POLY = 8'h07,
  parameter byte_t INIT = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dma_en_i,
  input  logic       pec_en_i,
  input  logic       last_i,
  input  logic       master_i,
  input  logic       mode_tx_i,
  input  logic       start_i,
  input  logic       pec_clr_i,
  input  logic       arb_lost_i,
  input  logic       dma_eot_i,
  input  logic       dma_eot1_i,
  input  logic       byte_done_i,
  input  logic [7:0] byte_i,
  input  logic       pec_err_clr_i,
  output logic [7:0] pec_o,
  output logic       pec_valid_o,
  output logic       tx_pec_select_o,
  output logic       nack_o,
  output logic       rx_dma_req_o,
  output logic       pec_err_o
);
  byte_t crc;
  logic  tx_arm, rx_arm;

  assign tx_arm = mode_tx_i & dma_en_i & pec_en_i & last_i & dma_eot_i;
  assign rx_arm = ~mode_tx_i & dma_en_i & last_i & dma_eot1_i;

  pec_crc_unit #(.POLY(POLY), .INIT(INIT)) u_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i | pec_clr_i),
    .upd_i      (byte_done_i & pec_en_i),
    .data_i     (byte_i),
    .arb_lost_i (arb_lost_i),
    .crc_o      (crc),
    .valid_o    (pec_valid_o)
  );

  pec_tx_seq u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .arm_i       (tx_arm),
    .byte_done_i (byte_done_i),
    .sel_o       (tx_pec_select_o)
  );

  pec_rx_seq u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .arm_i       (rx_arm),
    .chk_en_i    (pec_en_i),
    .master_i    (master_i),
    .rx_mode_i   (~mode_tx_i),
    .dma_en_i    (dma_en_i),
    .byte_done_i (byte_done_i),
    .byte_i      (byte_i),
    .crc_i       (crc),
    .err_clr_i   (pec_err_clr_i),
    .nack_o      (nack_o),
    .req_o       (rx_dma_req_o),
    .err_o       (pec_err_o)
  );

  assign pec_o = crc;
endmodule

// File: tb/i2c_pec_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_pec_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dma_en = 1'b1, pec_en = 1'b0, last = 1'b0, master = 1'b1, mode_tx = 1'b1;
  logic start = 1'b0, pec_clr = 1'b0, arb = 1'b0, eot = 1'b0, eot1 = 1'b0;
  logic bdone = 1'b0, eclr = 1'b0;
  logic [7:0] bval = 8'h00;
  logic [7:0] pec;
  logic valid, sel, nack, req, err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_pec_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en), .pec_en_i(pec_en),
    .last_i(last), .master_i(master), .mode_tx_i(mode_tx), .start_i(start),
    .pec_clr_i(pec_clr), .arb_lost_i(arb), .dma_eot_i(eot), .dma_eot1_i(eot1),
    .byte_done_i(bdone), .byte_i(bval), .pec_err_clr_i(eclr),
    .pec_o(pec), .pec_valid_o(valid), .tx_pec_select_o(sel), .nack_o(nack),
    .rx_dma_req_o(req), .pec_err_o(err)
  );

  // bitwise software CRC-8, poly 0x07
  function automatic int sw_crc(int c, int d);
    int r = c;
    for (int i = 7; i >= 0; i--) begin
      int fb = ((r >> 7) ^ (d >> i)) & 1;
      r = (r << 1) & 8'hff;
      if (fb != 0) r = r ^ 8'h07;
    end
    return r;
  endfunction

  // behavioural reference, advanced every clock
  int m_crc = 0;
  bit m_valid = 1, m_sel = 0, m_req = 0, m_err = 0, m_pend = 0, m_arm = 0, m_chk = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit eset;
      eset = bdone && m_arm && m_chk && (int'(bval) != m_crc);
      m_err = eset || (m_err && !eclr);
      m_req = bdone && !mode_tx && dma_en;
      m_sel = bdone && m_pend && !start;
      if (start) m_pend = 0;
      else if (mode_tx && dma_en && pec_en && last && eot) m_pend = 1;
      else if (bdone) m_pend = 0;
      if (start) begin m_arm = 0; m_chk = 0; end
      else if (!mode_tx && dma_en && last && eot1) begin m_arm = 1; m_chk = pec_en; end
      else if (bdone) m_arm = 0;
      if (start || pec_clr) m_crc = 0;
      else if (bdone && pec_en) m_crc = sw_crc(m_crc, int'(bval));
      if (start || pec_clr) m_valid = 1;
      else if (arb) m_valid = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 pec_o", int'(pec), m_crc);
      chk("R9 pec_valid_o", int'(valid), int'(m_valid));
      chk("R3 tx_pec_select_o", int'(sel), int'(m_sel));
      chk("R5 nack_o", int'(nack), int'(m_arm && master));
      chk("R8 rx_dma_req_o", int'(req), int'(m_req));
      chk("R7 pec_err_o", int'(err), int'(m_err));
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); bdone = 1'b1; bval = b;
    @(negedge clk); bdone = 1'b0;
  endtask
  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask
  task automatic do_eot();
    @(negedge clk); eot = 1'b1;
    @(negedge clk); eot = 1'b0;
  endtask
  task automatic do_eot1();
    @(negedge clk); eot1 = 1'b1;
    @(negedge clk); eot1 = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R2 reset pec", int'(pec), 0);
    chk("R9 reset valid", int'(valid), 1);
    chk("R7 reset err", int'(err), 0);

    // R1 random stream vs software CRC
    pec_en = 1'b1; mode_tx = 1'b1; last = 1'b0;
    do_start();
    acc = 0;
    for (int i = 0; i < 24; i++) begin
      logic [7:0] b = 8'($urandom);
      acc = sw_crc(acc, int'(b));
      send(b);
    end
    chk("R1 random stream", int'(pec), acc);
    pec_en = 1'b0;
    send(8'hA5);
    chk("R1 hold when disabled", int'(pec), acc);
    pec_en = 1'b1;

    // R2 clear wins over byte
    @(negedge clk); pec_clr = 1'b1; bdone = 1'b1; bval = 8'h3C;
    @(negedge clk); pec_clr = 1'b0; bdone = 1'b0;
    chk("R2 clear priority", int'(pec), 0);

    // R3 transmit append
    last = 1'b1;
    do_start();
    send(8'h5A); send(8'h01); send(8'hF0);
    do_eot();
    chk("R3 no early select", int'(sel), 0);
    send(8'h77);
    chk("R3 select after last byte", int'(sel), 1);
    @(negedge clk);
    chk("R3 select one cycle", int'(sel), 0);
    send(pec);
    chk("R3 zero residue", int'(pec), 0);

    // R4 no append without LAST or PEC
    last = 1'b0;
    do_start(); send(8'h12); do_eot(); send(8'h34);
    chk("R4 last clear no select", int'(sel), 0);
    last = 1'b1; pec_en = 1'b0;
    do_eot(); send(8'h56);
    chk("R4 pec off no select", int'(sel), 0);
    pec_en = 1'b1;

    // R5 R6 R8 receive, good checksum
    mode_tx = 1'b0; last = 1'b1;
    do_start();
    acc = 0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b = 8'($urandom);
      acc = sw_crc(acc, int'(b));
      send(b);
      chk("R8 req per byte", int'(req), 1);
      chk("R5 ack data byte", int'(nack), 0);
    end
    do_eot1();
    chk("R5 nack armed", int'(nack), 1);
    send(8'(acc));
    chk("R8 req on pec byte", int'(req), 1);
    chk("R6 good pec no err", int'(err), 0);
    chk("R5 nack released", int'(nack), 0);

    // R6 bad checksum
    do_start(); send(8'h10); send(8'h20);
    do_eot1();
    send(8'(sw_crc(sw_crc(0, 8'h10), 8'h20) ^ 8'h01));
    chk("R6 bad pec err", int'(err), 1);
    @(negedge clk);
    chk("R7 err sticky", int'(err), 1);
    @(negedge clk); eclr = 1'b1;
    @(negedge clk); eclr = 1'b0;
    chk("R7 err cleared", int'(err), 0);

    // R7 clear and new error together
    do_start(); send(8'h99); do_eot1();
    @(negedge clk); eclr = 1'b1; bdone = 1'b1; bval = 8'h00;
    @(negedge clk); eclr = 1'b0; bdone = 1'b0;
    chk("R7 set wins over clear", int'(err), 1);
    @(negedge clk); eclr = 1'b1;
    @(negedge clk); eclr = 1'b0;

    // R10 intermediate segment
    last = 1'b0;
    do_start(); send(8'h44); do_eot1();
    chk("R10 no nack", int'(nack), 0);
    send(8'hEE);
    chk("R10 no check", int'(err), 0);

    // R5 slave receiver never NACKs
    last = 1'b1; master = 1'b0;
    do_start(); send(8'h44); do_eot1();
    chk("R5 slave no nack", int'(nack), 0);
    send(8'(sw_crc(0, 8'h44)));
    master = 1'b1;

    // R9 arbitration loss
    @(negedge clk); arb = 1'b1;
    @(negedge clk); arb = 1'b0;
    chk("R9 invalid after arb", int'(valid), 0);
    send(8'h61);
    chk("R9 stays invalid", int'(valid), 0);
    @(negedge clk); pec_clr = 1'b1;
    @(negedge clk); pec_clr = 1'b0;
    chk("R9 valid after clear", int'(valid), 1);
    chk("R2 pec after clear", int'(pec), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule